// File: doc/BRIEF.md
# BCD Calendar Counter

This block keeps time of day and a calendar in binary-coded decimal. Seven byte fields make up the state: seconds, minutes, hours, weekday, day of month, month and a two-digit year standing for 2000 to 2099. A strobe input `tick_i` arrives at a fixed rate of `TICKS_PER_SEC` pulses per second. An internal phase counter turns that strobe into one advance per second. Each advance steps the seconds and ripples carries up through the fields. Each field stays within its legal decimal range, and the day of month follows the length of the current month and leap years.

The hour byte carries its own format. Its bit 6 chooses 12-hour form, and in that form bit 5 marks PM. Counting follows whatever format is stored in the byte. A host writes fields through a simple write port, and any field can be read back combinationally through a read port. A control byte holds an oscillator-stop bit that freezes counting.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour), weekday 0x01, date 0x01, month 0x01, year 0x00, and control 0x00.
- R2: The seconds field advances once per `TICKS_PER_SEC` strobes of `tick_i`. Seconds and minutes each go 0x59 to 0x00, and that wrap carries one into the next field up.
- R3: With hour bit 6 clear, hours count 0x00 to 0x23. Going from 0x23 to 0x00 carries one day.
- R4: With hour bit 6 set, bits 4:0 hold the hour as 0x01 to 0x12 and bit 5 holds PM. Going from 11 to 12 toggles PM. Going from 12 to 1 keeps PM. Only 11 PM to 12 AM carries one day.
- R5: The weekday (address 3) counts 1 to 7 and goes from 7 back to 1 on each day carry.
- R6: The date (address 4) goes back to 0x01 after the last day of the month and carries into the month. Months 01, 03, 05, 07, 08, 10 and 12 end at 31, and months 04, 06, 09 and 11 end at 30. February ends at 29 when the year is divisible by 4 (year 00 included) and at 28 otherwise.
- R7: The month (address 5) goes from 0x12 to 0x01 and carries into the year (address 6). The year goes from 0x99 to 0x00.
- R8: While control (address 7) bit 7 is set, no field advances and the sub-second phase is held. When the bit is cleared, counting resumes from the held phase. Writing control does not restart the phase.
- R9: A write to any of addresses 0 to 6 restarts the phase, so the next advance comes exactly `TICKS_PER_SEC` strobes later. If a second would have completed in the same cycle as that write, that advance is dropped.
- R10: Addresses are seconds 0, minutes 1, hours 2, weekday 3, date 4, month 5, year 6 and control 7. Writes store only the implemented bits, and reads return zero in the others. The masks are 0x7F, 0x7F, 0x7F, 0x07, 0x3F, 0x1F, 0xFF and 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sub-second strobe, `TICKS_PER_SEC` per second |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Host write address |
| wr_data_i | input | 8 | Host write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data for `rd_addr_i`, combinational |

## Verification
Two functions can fall in the same cycle: a host write to a time field and the strobe that would complete a second. The bench provokes this by letting the phase reach its last step with three strobes and then issuing a minutes write together with the fourth strobe. It then expects the seconds to be unchanged, the written minutes to be in place, and the next advance to come a full second later. Around this, the bench sweeps every hour in both hour formats and every month end of all hundred years, and predicts each result arithmetically from binary time values.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef logic [7:0] byte_t;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC  = 3'd0,
    A_MIN  = 3'd1,
    A_HOUR = 3'd2,
    A_WDAY = 3'd3,
    A_DATE = 3'd4,
    A_MON  = 3'd5,
    A_YEAR = 3'd6,
    A_CTRL = 3'd7
  } reg_addr_e;

  localparam byte_t MASK_SEXA = 8'h7F;
  localparam byte_t MASK_HOUR = 8'h7F;
  localparam byte_t MASK_WDAY = 8'h07;
  localparam byte_t MASK_DATE = 8'h3F;
  localparam byte_t MASK_MON  = 8'h1F;
  localparam byte_t MASK_YEAR = 8'hFF;
  localparam byte_t MASK_CTRL = 8'h80;

  localparam int unsigned HR12_BIT = 6;
  localparam int unsigned PM_BIT   = 5;
  localparam int unsigned HALT_BIT = 7;

  function automatic byte_t bcd_inc(byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by 4: even tens with 0/4/8, odd tens with 2/6
  function automatic logic leap_year(byte_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic byte_t month_end(byte_t mon, byte_t yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_prescaler.sv
`timescale 1ns/1ps
module rtc_cal_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic halt_i,
  input  logic restart_i,
  output logic sec_stb_o
);
  localparam int unsigned CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (tick_i && !halt_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  assign sec_stb_o = tick_i & ~halt_i & ~restart_i & at_last;

  AST_HALT_HOLDS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !restart_i) |=> $stable(cnt_q)); // R8
  AST_RESTART_CLEARS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0)); // R9
  AST_STB_NOT_ON_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_stb_o |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/rtc_cal_clock.sv
`timescale 1ns/1ps
module rtc_cal_clock
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sec_stb_i,
  input  logic [2:0] we_i,
  input  byte_t      wdata_i,
  output byte_t      sec_o,
  output byte_t      min_o,
  output byte_t      hour_o,
  output logic       day_stb_o
);
  logic [2:0] stb;
  byte_t      hour_q, hour_nxt;
  logic       hour_roll;

  assign stb[0] = sec_stb_i;

  // seconds and minutes share one base-60 counter shape
  for (genvar i = 0; i < 2; i++) begin : g_sexa
    byte_t q;
    logic  wrap;
    assign wrap     = (q >= 8'h59);
    assign stb[i+1] = stb[i] & wrap;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= 8'h00;
      else if (we_i[i]) q <= wdata_i & MASK_SEXA;
      else if (stb[i])  q <= wrap ? 8'h00 : bcd_inc(q);
    end
  end

  assign sec_o = g_sexa[0].q;
  assign min_o = g_sexa[1].q;

  always_comb begin
    byte_t inc;
    hour_roll = 1'b0;
    if (!hour_q[HR12_BIT]) begin
      inc = bcd_inc({2'b00, hour_q[5:0]});
      if (hour_q[5:0] >= 6'h23) begin
        hour_nxt  = 8'h00;
        hour_roll = 1'b1;
      end else begin
        hour_nxt = {2'b00, inc[5:0]};
      end
    end else begin
      inc = bcd_inc({3'b000, hour_q[4:0]});
      if (hour_q[4:0] == 5'h12) begin
        hour_nxt = {2'b01, hour_q[PM_BIT], 5'h01};
      end else if (hour_q[4:0] == 5'h11) begin
        hour_nxt  = {2'b01, ~hour_q[PM_BIT], 5'h12};
        hour_roll = hour_q[PM_BIT];
      end else begin
        hour_nxt = {2'b01, hour_q[PM_BIT], inc[4:0]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hour_q <= 8'h00;
    else if (we_i[2]) hour_q <= wdata_i & MASK_HOUR;
    else if (stb[2])  hour_q <= hour_nxt;
  end

  assign hour_o    = hour_q;
  assign day_stb_o = stb[2] & hour_roll;

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_stb_i && we_i == 3'b000 && sec_o == 8'h59) |=> (sec_o == 8'h00)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_stb_i && we_i == 3'b000) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_q))); // R8
  AST_H24_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb[2] && we_i == 3'b000 && hour_q == 8'h23) |=> (hour_q == 8'h00)); // R3
  AST_PM_MIDNIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb[2] && hour_q == 8'h71) |-> day_stb_o); // R4
  AST_NOON_NO_DAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hour_q == 8'h51) |-> !day_stb_o); // R4
endmodule

// File: rtl/rtc_cal_date.sv
`timescale 1ns/1ps
module rtc_cal_date
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       day_stb_i,
  input  logic [3:0] we_i,
  input  byte_t      wdata_i,
  output byte_t      wday_o,
  output byte_t      date_o,
  output byte_t      mon_o,
  output byte_t      year_o
);
  byte_t wday_q, date_q, mon_q, year_q;
  logic  date_wrap, mon_wrap, mon_stb, year_stb;

  assign date_wrap = (date_q >= month_end(mon_q, year_q));
  assign mon_wrap  = (mon_q >= 8'h12);
  assign mon_stb   = day_stb_i & date_wrap;
  assign year_stb  = mon_stb & mon_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wday_q <= 8'h01;
    else if (we_i[0])   wday_q <= wdata_i & MASK_WDAY;
    else if (day_stb_i) wday_q <= (wday_q >= 8'h07) ? 8'h01 : wday_q + 8'h01;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        date_q <= 8'h01;
    else if (we_i[1])   date_q <= wdata_i & MASK_DATE;
    else if (day_stb_i) date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mon_q <= 8'h01;
    else if (we_i[2]) mon_q <= wdata_i & MASK_MON;
    else if (mon_stb) mon_q <= mon_wrap ? 8'h01 : bcd_inc(mon_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       year_q <= 8'h00;
    else if (we_i[3])  year_q <= wdata_i & MASK_YEAR;
    else if (year_stb) year_q <= (year_q >= 8'h99) ? 8'h00 : bcd_inc(year_q);
  end

  assign wday_o = wday_q;
  assign date_o = date_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;

  AST_WDAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_stb_i && we_i == 4'b0000 && wday_q == 8'h07) |=> (wday_q == 8'h01)); // R5
  AST_FEB_LEAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_stb_i && we_i == 4'b0000 && mon_q == 8'h02 && date_q == 8'h28 && year_q == 8'h24)
    |=> (date_q == 8'h29)); // R6
  AST_YEAR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (year_stb && we_i == 4'b0000 && year_q == 8'h99) |=> (year_q == 8'h00)); // R7
  AST_DATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!day_stb_i && we_i == 4'b0000) |=> ($stable(date_q) && $stable(mon_q) && $stable(year_q))); // R6
endmodule

// File: rtl/rtc_cal_top.sv
`timescale 1ns/1ps
module rtc_cal_top
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [2:0] rd_addr_i,
  output logic [7:0] rd_data_o
);
  localparam int unsigned NREG = 1 << ADDR_W;

  logic [NREG-1:0] fld_we;
  logic            time_wr, halt_q, sec_stb, day_stb;
  byte_t           sec, min, hour, wday, date, mon, year;

  assign fld_we  = wr_en_i ? (NREG'(1) << wr_addr_i) : '0;
  assign time_wr = wr_en_i && (wr_addr_i != A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             halt_q <= 1'b0;
    else if (fld_we[A_CTRL]) halt_q <= wr_data_i[HALT_BIT];
  end

  rtc_cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .halt_i    (halt_q),
    .restart_i (time_wr),
    .sec_stb_o (sec_stb)
  );

  rtc_cal_clock u_clock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_stb_i (sec_stb),
    .we_i      (fld_we[A_HOUR:A_SEC]),
    .wdata_i   (wr_data_i),
    .sec_o     (sec),
    .min_o     (min),
    .hour_o    (hour),
    .day_stb_o (day_stb)
  );

  rtc_cal_date u_date (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .day_stb_i (day_stb),
    .we_i      (fld_we[A_YEAR:A_WDAY]),
    .wdata_i   (wr_data_i),
    .wday_o    (wday),
    .date_o    (date),
    .mon_o     (mon),
    .year_o    (year)
  );

  always_comb begin
    case (rd_addr_i)
      A_SEC:   rd_data_o = sec;
      A_MIN:   rd_data_o = min;
      A_HOUR:  rd_data_o = hour;
      A_WDAY:  rd_data_o = wday;
      A_DATE:  rd_data_o = date;
      A_MON:   rd_data_o = mon;
      A_YEAR:  rd_data_o = year;
      default: rd_data_o = {halt_q, 7'b0};
    endcase
  end

  AST_HALT_NO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |-> !sec_stb); // R8
  AST_WRITE_DROPS_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_wr |-> !sec_stb); // R9
endmodule

// File: tb/rtc_cal_top_tb_top.sv
`timescale 1ns/1ps
module rtc_cal_top_tb_top;
  localparam int unsigned TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  rtc_cal_top #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  function automatic logic [7:0] bcd(int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic logic [7:0] enc_hour(bit m12, int h);
    int hr;
    if (!m12) return bcd(h);
    hr = h % 12;
    if (hr == 0) hr = 12;
    return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | bcd(hr);
  endfunction

  function automatic int last_day(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(posedge clk); #1;
      tick = 1'b0;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, bit with_tick);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = with_tick;
    @(posedge clk); #1;
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic check(logic [2:0] a, logic [7:0] exp, string tag);
    rd_addr = a;
    @(posedge clk); #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0d got %02h expected %02h", tag, a, rd_data, exp);
    end
  endtask

  task automatic set_all(int s, int m, logic [7:0] hb, int wd, int d, int mo, int y);
    wr(3'd0, bcd(s), 0);
    wr(3'd1, bcd(m), 0);
    wr(3'd2, hb, 0);
    wr(3'd3, 8'(wd), 0);
    wr(3'd4, bcd(d), 0);
    wr(3'd5, bcd(mo), 0);
    wr(3'd6, bcd(y), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check(3'd0, 8'h00, "R1"); check(3'd1, 8'h00, "R1");
    check(3'd2, 8'h00, "R1"); check(3'd3, 8'h01, "R1");
    check(3'd4, 8'h01, "R1"); check(3'd5, 8'h01, "R1");
    check(3'd6, 8'h00, "R1"); check(3'd7, 8'h00, "R1");

    // R10 field masks
    begin
      logic [7:0] msk [8] = '{8'h7F, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'h1F, 8'hFF, 8'h80};
      for (int a = 0; a < 8; a++) begin
        wr(3'(a), 8'hFF, 0);
        check(3'(a), msk[a], "R10");
      end
      wr(3'd7, 8'h00, 0);
      check(3'd7, 8'h00, "R10");
    end

    // R2 one hour of seconds with carries
    set_all(0, 0, 8'h00, 1, 1, 1, 0);
    for (int i = 1; i <= 3600; i++) begin
      ticks(TPS);
      check(3'd0, bcd(i % 60), "R2");
      check(3'd1, bcd((i / 60) % 60), "R2");
      check(3'd2, bcd(i / 3600), "R2");
    end

    // R3 / R4 every hour in both formats
    for (int md = 0; md < 2; md++) begin
      for (int h = 0; h < 24; h++) begin
        string tg;
        tg = md ? "R4" : "R3";
        set_all(58, 59, enc_hour(md[0], h), 3, 10, 5, 21);
        ticks(2 * TPS);
        check(3'd0, 8'h00, tg);
        check(3'd1, 8'h00, tg);
        check(3'd2, enc_hour(md[0], (h + 1) % 24), tg);
        check(3'd4, (h == 23) ? 8'h11 : 8'h10, tg);
        check(3'd3, (h == 23) ? 8'h04 : 8'h03, "R5");
      end
    end

    // R5 / R6 / R7 month ends of every year
    for (int y = 0; y < 100; y++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        for (int k = 0; k < 2; k++) begin
          int d, wd;
          d  = last_day(mo, y) - k;
          wd = ((y * 12 + mo + k) % 7) + 1;
          set_all(59, 59, 8'h23, wd, d, mo, y);
          ticks(TPS);
          check(3'd3, 8'((wd == 7) ? 1 : wd + 1), "R5");
          if (k == 0) begin
            check(3'd4, 8'h01, "R6");
            check(3'd5, bcd((mo == 12) ? 1 : mo + 1), "R7");
            check(3'd6, bcd((mo == 12) ? (y + 1) % 100 : y), "R7");
          end else begin
            check(3'd4, bcd(d + 1), "R6");
            check(3'd5, bcd(mo), "R6");
          end
        end
      end
    end

    // R8 stop bit holds time and phase
    set_all(10, 0, 8'h00, 1, 1, 1, 0);
    ticks(2);
    wr(3'd7, 8'h80, 0);
    ticks(20);
    check(3'd0, bcd(10), "R8");
    wr(3'd7, 8'h00, 0);
    ticks(1);
    check(3'd0, bcd(10), "R8");
    ticks(1);
    check(3'd0, bcd(11), "R8");

    // R9 phase restart and same-cycle collision
    wr(3'd0, 8'h20, 0);
    ticks(TPS - 1);
    check(3'd0, 8'h20, "R9");
    ticks(1);
    check(3'd0, 8'h21, "R9");
    ticks(TPS - 1);
    wr(3'd1, 8'h05, 1);
    check(3'd0, 8'h21, "R9");
    check(3'd1, 8'h05, "R9");
    ticks(TPS - 1);
    check(3'd0, 8'h21, "R9");
    ticks(1);
    check(3'd0, 8'h22, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule